// File: doc/BRIEF.md
# Packed-Lane Vector Arithmetic Unit

This unit is a pipelined functional unit for a wide-word media datapath. It treats each 64-bit operand as a packed vector of 8-bit, 16-bit or 32-bit lanes, chosen per operation. It computes lane-wise addition, subtraction, equality compare and greater-than compare. A 6-bit opcode selects the lane width, the signed or unsigned reading of the lanes, and whether sums clip to the lane's range or wrap around.

One segmented adder serves every lane width. Each carry between 8-bit segments is cut at lane boundaries. A second pipeline stage holds a post-processing slice for each lane width. That slice turns per-lane carries and sign bits into clipped sums or compare masks. The unit takes one operation per cycle and returns each result a fixed two cycles after it is accepted.

Top module: `vsimd_alu`

## Requirements
- R1: op_i[3:2] selects the lane width: 00 = 8-bit, 01 = 16-bit, 10 = 32-bit lanes. The code 11 behaves exactly as 10.
- R2: op_i[1:0] = 00 adds and 01 subtracts (a minus b). With op_i[5] = 0, each lane result is the sum or difference modulo 2^w, and no carry or borrow crosses a lane boundary.
- R3: With op_i[5] = 1 and op_i[4] = 0, addition and subtraction treat lanes as unsigned and clip to the range 0 to 2^w-1.
- R4: With op_i[5] = 1 and op_i[4] = 1, addition and subtraction treat lanes as two's complement and clip to the range -2^(w-1) to 2^(w-1)-1.
- R5: op_i[1:0] = 10 compares each lane pair for equality. It writes all ones into a lane that is equal and all zeros into a lane that is not. op_i[5] has no effect.
- R6: op_i[1:0] = 11 writes all ones into a lane where a > b and all zeros into any other lane. The compare is signed when op_i[4] = 1 and unsigned when op_i[4] = 0. op_i[5] has no effect.
- R7: valid_o is high exactly two cycles after each cycle in which valid_i is high, and at no other time. A new operation is accepted every cycle.
- R8: While rst_ni is low, valid_o and result_o are 0.
- R9: result_o keeps its value in every cycle in which valid_o is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Operation valid |
| op_i | input | 6 | Opcode: [5] clip, [4] signed, [3:2] lane width, [1:0] function |
| a_i | input | 64 | First operand |
| b_i | input | 64 | Second operand |
| valid_o | output | 1 | Result valid |
| result_o | output | 64 | Lane-wise result |

## Verification
The checker follows the operations it sees on the inputs through its own two-stage copy. On every cycle it checks four things against that copy: the two-cycle valid timing, that the result holds while idle, the lane-isolated wrap-around sums, and the unsigned clipping bounds. It also checks that every compare lane is either all ones or all zeros. Only the bench's sweeps show the exact clipped values at the signed and unsigned extremes, the compare outcomes at equal and boundary operands, and the aliasing of the reserved width code. The bench sweeps all 64 opcodes against corner lane values issued back to back, then runs a random phase with idle gaps.

// File: rtl/vsimd_pkg.sv
package vsimd_pkg;
  localparam int OP_W = 6;

  typedef enum logic [1:0] {
    FN_ADD = 2'b00,
    FN_SUB = 2'b01,
    FN_CEQ = 2'b10,
    FN_CGT = 2'b11
  } fn_e;

  typedef enum logic [1:0] {
    LW_8   = 2'b00,
    LW_16  = 2'b01,
    LW_32  = 2'b10,
    LW_32R = 2'b11
  } lw_e;

  // bit 5 clip, bit 4 signed, bits 3:2 width, bits 1:0 function
  typedef struct packed {
    logic sat;
    logic sgn;
    lw_e  lw;
    fn_e  fn;
  } op_t;

  function automatic logic [1:0] lw_index(lw_e lw);
    return (lw == LW_32R) ? 2'd2 : lw;
  endfunction
endpackage

// File: rtl/vsimd_seg_adder.sv
module vsimd_seg_adder #(
  parameter int DATA_W = 64,
  parameter int SEG_W  = 8,
  localparam int NSEG  = DATA_W / SEG_W
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic              sub_i,
  input  logic [NSEG-1:0]   start_i,
  output logic [DATA_W-1:0] sum_o,
  output logic [NSEG-1:0]   cry_o
);
  logic [NSEG-1:0] co;

  for (genvar i = 0; i < NSEG; i++) begin : g_seg
    logic             cin;
    logic             prev;
    logic [SEG_W-1:0] b_eff;
    if (i == 0) begin : g_first
      assign prev = 1'b0;
    end else begin : g_rest
      assign prev = co[i-1];
    end
    // lane start injects the subtract carry, else chain from below
    assign cin   = start_i[i] ? sub_i : prev;
    assign b_eff = b_i[i*SEG_W +: SEG_W] ^ {SEG_W{sub_i}};
    assign {co[i], sum_o[i*SEG_W +: SEG_W]} =
        {1'b0, a_i[i*SEG_W +: SEG_W]} + {1'b0, b_eff} + {{SEG_W{1'b0}}, cin};
  end

  assign cry_o = co;
endmodule

// File: rtl/vsimd_lane_post.sv
module vsimd_lane_post
  import vsimd_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int SEG_W  = 8,
  parameter int LANE_W = 16,
  localparam int NSEG  = DATA_W / SEG_W,
  localparam int NLANE = DATA_W / LANE_W,
  localparam int SPL   = LANE_W / SEG_W
) (
  input  fn_e               fn_i,
  input  logic              sgn_i,
  input  logic              sat_i,
  input  logic [DATA_W-1:0] sum_i,
  input  logic [NSEG-1:0]   cry_i,
  input  logic [NSEG-1:0]   amsb_i,
  input  logic [NSEG-1:0]   bmsb_i,
  output logic [DATA_W-1:0] res_o
);
  localparam logic [LANE_W-1:0] SMAX = {1'b0, {(LANE_W-1){1'b1}}};
  localparam logic [LANE_W-1:0] SMIN = {1'b1, {(LANE_W-1){1'b0}}};
  localparam logic [LANE_W-1:0] UMAX = {LANE_W{1'b1}};

  logic unused_segs;
  assign unused_segs = ^{cry_i, amsb_i, bmsb_i};

  logic is_sub;
  assign is_sub = (fn_i != FN_ADD);

  for (genvar l = 0; l < NLANE; l++) begin : g_lane
    localparam int TOP = l * SPL + SPL - 1;
    logic [LANE_W-1:0] r;
    logic [LANE_W-1:0] y;
    logic c, sa, sb, sr, ovf_s, ovf_u, zero, gt;

    assign r     = sum_i[l*LANE_W +: LANE_W];
    assign c     = cry_i[TOP];
    assign sa    = amsb_i[TOP];
    assign sb    = bmsb_i[TOP];
    assign sr    = r[LANE_W-1];
    assign ovf_s = is_sub ? ((sa ^ sb) & (sr ^ sa)) : (~(sa ^ sb) & (sr ^ sa));
    assign ovf_u = is_sub ? ~c : c;
    assign zero  = ~|r;
    // a - b: signed less-than is sign xor overflow; unsigned carry means a >= b
    assign gt    = sgn_i ? (~(sr ^ ovf_s) & ~zero) : (c & ~zero);

    always_comb begin
      y = r;
      unique case (fn_i)
        FN_CEQ: y = {LANE_W{zero}};
        FN_CGT: y = {LANE_W{gt}};
        default: begin
          if (sat_i && sgn_i && ovf_s) begin
            y = sa ? SMIN : SMAX;
          end else if (sat_i && !sgn_i && ovf_u) begin
            y = is_sub ? '0 : UMAX;
          end
        end
      endcase
    end

    assign res_o[l*LANE_W +: LANE_W] = y;
  end
endmodule

// File: rtl/vsimd_alu.sv
module vsimd_alu
  import vsimd_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int SEG_W  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [OP_W-1:0]   op_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  output logic              valid_o,
  output logic [DATA_W-1:0] result_o
);
  localparam int NSEG = DATA_W / SEG_W;
  localparam int NWID = 3;

  op_t               op;
  logic [NSEG-1:0]   seg_start;
  logic [DATA_W-1:0] add_sum;
  logic [NSEG-1:0]   add_cry;
  logic [NSEG-1:0]   a_msb, b_msb;

  assign op = op_t'(op_i);

  always_comb begin
    int spl;
    spl = 1 << lw_index(op.lw);
    for (int i = 0; i < NSEG; i++) begin
      seg_start[i] = ((i % spl) == 0);
    end
  end

  for (genvar i = 0; i < NSEG; i++) begin : g_msb
    assign a_msb[i] = a_i[i*SEG_W + SEG_W - 1];
    assign b_msb[i] = b_i[i*SEG_W + SEG_W - 1];
  end

  vsimd_seg_adder #(
    .DATA_W(DATA_W),
    .SEG_W (SEG_W)
  ) u_add (
    .a_i    (a_i),
    .b_i    (b_i),
    .sub_i  (op.fn != FN_ADD),
    .start_i(seg_start),
    .sum_o  (add_sum),
    .cry_o  (add_cry)
  );

  // stage 1
  logic              s1_vld;
  op_t               s1_op;
  logic [DATA_W-1:0] s1_sum;
  logic [NSEG-1:0]   s1_cry, s1_amsb, s1_bmsb;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_vld  <= 1'b0;
      s1_op   <= '0;
      s1_sum  <= '0;
      s1_cry  <= '0;
      s1_amsb <= '0;
      s1_bmsb <= '0;
    end else begin
      s1_vld <= valid_i;
      if (valid_i) begin
        s1_op   <= op;
        s1_sum  <= add_sum;
        s1_cry  <= add_cry;
        s1_amsb <= a_msb;
        s1_bmsb <= b_msb;
      end
    end
  end

  // stage 2: one post slice per lane width
  logic [DATA_W-1:0] res_w [NWID];
  logic [DATA_W-1:0] res_sel;

  for (genvar w = 0; w < NWID; w++) begin : g_wid
    vsimd_lane_post #(
      .DATA_W(DATA_W),
      .SEG_W (SEG_W),
      .LANE_W(SEG_W << w)
    ) u_post (
      .fn_i  (s1_op.fn),
      .sgn_i (s1_op.sgn),
      .sat_i (s1_op.sat),
      .sum_i (s1_sum),
      .cry_i (s1_cry),
      .amsb_i(s1_amsb),
      .bmsb_i(s1_bmsb),
      .res_o (res_w[w])
    );
  end

  always_comb begin
    unique case (lw_index(s1_op.lw))
      2'd0:    res_sel = res_w[0];
      2'd1:    res_sel = res_w[1];
      default: res_sel = res_w[2];
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o  <= 1'b0;
      result_o <= '0;
    end else begin
      valid_o <= s1_vld;
      if (s1_vld) result_o <= res_sel;
    end
  end
endmodule

// File: rtl/vsimd_alu_chk.sv
module vsimd_alu_chk #(
  parameter int DATA_W = 64,
  parameter int SEG_W  = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              valid_i,
  input logic [5:0]        op_i,
  input logic [DATA_W-1:0] a_i,
  input logic [DATA_W-1:0] b_i,
  input logic              valid_o,
  input logic [DATA_W-1:0] result_o
);
  localparam int NSEG = DATA_W / SEG_W;

  logic              vd1, vd2;
  logic [5:0]        op1, op2;
  logic [DATA_W-1:0] a1, a2, b1, b2;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vd1 <= 1'b0; vd2 <= 1'b0;
      op1 <= '0;   op2 <= '0;
      a1  <= '0;   a2  <= '0;
      b1  <= '0;   b2  <= '0;
    end else begin
      vd1 <= valid_i; vd2 <= vd1;
      op1 <= op_i;    op2 <= op1;
      a1  <= a_i;     a2  <= a1;
      b1  <= b_i;     b2  <= b1;
    end
  end

  function automatic int lane_bits(logic [5:0] op);
    return SEG_W << ((op[3:2] == 2'b11) ? 2 : int'(op[3:2]));
  endfunction

  function automatic logic [DATA_W-1:0] lane(logic [DATA_W-1:0] x, int l, int w);
    logic [DATA_W-1:0] m;
    m = {DATA_W{1'b1}} >> (DATA_W - w);
    return (x >> (l * w)) & m;
  endfunction

  function automatic logic wrap_ok(logic [5:0] op, logic [DATA_W-1:0] a, b, r);
    int w;
    logic [DATA_W-1:0] m, e;
    w = lane_bits(op);
    m = {DATA_W{1'b1}} >> (DATA_W - w);
    for (int l = 0; l < NSEG; l++) begin
      if (l * w < DATA_W) begin
        e = (op[0] ? lane(a, l, w) - lane(b, l, w) : lane(a, l, w) + lane(b, l, w)) & m;
        if (lane(r, l, w) != e) return 1'b0;
      end
    end
    return 1'b1;
  endfunction

  function automatic logic usat_ok(logic [5:0] op, logic [DATA_W-1:0] a, b, r);
    int w;
    w = lane_bits(op);
    for (int l = 0; l < NSEG; l++) begin
      if (l * w < DATA_W) begin
        if (op[0]) begin
          if (lane(r, l, w) > lane(a, l, w)) return 1'b0;
        end else begin
          if (lane(r, l, w) < lane(a, l, w) || lane(r, l, w) < lane(b, l, w)) return 1'b0;
        end
      end
    end
    return 1'b1;
  endfunction

  function automatic logic cmp_ok(logic [5:0] op, logic [DATA_W-1:0] r);
    int w;
    logic [DATA_W-1:0] m;
    w = lane_bits(op);
    m = {DATA_W{1'b1}} >> (DATA_W - w);
    for (int l = 0; l < NSEG; l++) begin
      if (l * w < DATA_W) begin
        if (lane(r, l, w) != '0 && lane(r, l, w) != m) return 1'b0;
      end
    end
    return 1'b1;
  endfunction

  AST_VALID_LAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o == vd2); // R7

  AST_HOLD_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> $stable(result_o)); // R9

  AST_WRAP_LANES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !op2[1] && !op2[5]) |-> wrap_ok(op2, a2, b2, result_o)); // R2

  AST_USAT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !op2[1] && op2[5] && !op2[4]) |-> usat_ok(op2, a2, b2, result_o)); // R3

  AST_CMP_MASK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && op2[1]) |-> cmp_ok(op2, result_o)); // R5
endmodule

bind vsimd_alu vsimd_alu_chk #(.DATA_W(DATA_W), .SEG_W(SEG_W)) u_chk (.*);

// File: tb/vsimd_alu_tb.sv
`timescale 1ns/1ps
module vsimd_alu_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic [5:0]  op_i = '0;
  logic [63:0] a_i = '0, b_i = '0;
  logic        valid_o;
  logic [63:0] result_o;

  vsimd_alu u_dut (.*);

  always #2.5 clk_i = ~clk_i;

  int checks = 0, errors = 0, cyc = 0;
  logic        mon_en = 1'b0;
  logic [63:0] q_res [16];
  logic [5:0]  q_op  [16];
  int          q_cyc [16];
  int          wp = 0, rp = 0;
  logic [63:0] last_res = '0;

  always @(posedge clk_i) cyc <= cyc + 1;

  function automatic logic [63:0] ref_calc(logic [5:0] op, logic [63:0] a, logic [63:0] b);
    int w, n;
    longint m, ua, ub, sa, sb, v, lo, hi;
    logic [63:0] res;
    w = 8 << ((op[3:2] == 2'b11) ? 2 : int'(op[3:2]));
    n = 64 / w;
    m = (longint'(1) << w) - 1;
    res = '0;
    for (int l = 0; l < n; l++) begin
      ua = longint'(a >> (l * w)) & m;
      ub = longint'(b >> (l * w)) & m;
      sa = (ua >= (longint'(1) << (w - 1))) ? ua - (longint'(1) << w) : ua;
      sb = (ub >= (longint'(1) << (w - 1))) ? ub - (longint'(1) << w) : ub;
      case (op[1:0])
        2'b10: v = (ua == ub) ? m : 0;
        2'b11: v = (op[4] ? (sa > sb) : (ua > ub)) ? m : 0;
        default: begin
          if (op[4]) v = op[0] ? sa - sb : sa + sb;
          else       v = op[0] ? ua - ub : ua + ub;
          if (op[5]) begin
            lo = op[4] ? -(longint'(1) << (w - 1)) : 0;
            hi = op[4] ? (longint'(1) << (w - 1)) - 1 : m;
            if (v < lo) v = lo;
            if (v > hi) v = hi;
          end
        end
      endcase
      res = res | ((64'(v) & 64'(m)) << (l * w));
    end
    return res;
  endfunction

  function automatic string tag_of(logic [5:0] op);
    if (op[3:2] == 2'b11) return "R1";
    case (op[1:0])
      2'b10: return "R5";
      2'b11: return "R6";
      default: begin
        if (!op[5]) return "R2";
        if (op[4]) return "R4";
        return "R3";
      end
    endcase
  endfunction

  function automatic longint corner(int k, int w);
    longint m;
    m = (longint'(1) << w) - 1;
    case (k)
      0: return 0;
      1: return 1;
      2: return (longint'(1) << (w - 1)) - 1;
      3: return longint'(1) << (w - 1);
      4: return m;
      default: return 64'h5A3C_96E1_A5C3_691E & m;
    endcase
  endfunction

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  always @(negedge clk_i) begin
    if (mon_en) begin
      if (valid_o) begin
        if (rp == wp) begin
          check("R7 spurious valid_o", 64'd1, 64'd0);
        end else begin
          check(tag_of(q_op[rp % 16]), result_o, q_res[rp % 16]);
          check("R7 latency", 64'(cyc - q_cyc[rp % 16]), 64'd2);
          rp++;
        end
        last_res = result_o;
      end else begin
        check("R9 hold", result_o, last_res);
      end
    end
  end

  task automatic issue(input logic [5:0] op, input logic [63:0] a, input logic [63:0] b);
    @(posedge clk_i); #1;
    valid_i = 1'b1; op_i = op; a_i = a; b_i = b;
    q_op[wp % 16] = op; q_res[wp % 16] = ref_calc(op, a, b); q_cyc[wp % 16] = cyc;
    wp++;
  endtask

  task automatic idle();
    @(posedge clk_i); #1;
    valid_i = 1'b0; op_i = 6'($urandom); a_i = {$urandom, $urandom}; b_i = {$urandom, $urandom};
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk_i);
    check("R8 valid_o in reset", 64'(valid_o), 64'd0);
    check("R8 result_o in reset", result_o, 64'd0);
    @(posedge clk_i); #1;
    rst_ni = 1'b1;
    mon_en = 1'b1;
    // sweep every opcode against corner lane pairs, back to back
    for (int op = 0; op < 64; op++) begin
      for (int i = 0; i < 36; i++) begin
        int w;
        logic [63:0] a, b;
        w = 8 << ((op[3:2] == 2'b11) ? 2 : op[3:2]);
        a = '0; b = '0;
        for (int l = 0; l < 64 / w; l++) begin
          int p;
          p = (i + l * 7) % 36;
          a = a | (64'(corner(p / 6, w)) << (l * w));
          b = b | (64'(corner(p % 6, w)) << (l * w));
        end
        issue(6'(op), a, b);
      end
    end
    // idle gap: valid_o must drop, result_o must hold
    repeat (5) idle();
    // random operations with random gaps
    for (int i = 0; i < 600; i++) begin
      if ($urandom_range(0, 3) == 0) idle();
      issue(6'($urandom), {$urandom, $urandom}, {$urandom, $urandom});
    end
    repeat (5) idle();
    check("R7 all results delivered", 64'(rp), 64'(wp));
    finish_run();
  end
endmodule